// File: doc/BRIEF.md
# Instruction Prefix and Opcode Scanner

This block is the front end of an instruction length and field decoder. A start pulse arms it, and it then takes instruction bytes one at a time from a valid/ready byte stream. It first sorts any leading legacy prefixes into a 16-bit flag word and counts them. In 64-bit mode it also takes a REX prefix, which always closes the prefix run. It then gathers one, two or three opcode bytes, following the escape rules. From the flags and the mode it derives the effective operand size and address size in bytes.

The stream follows ordinary back-pressure rules. A byte moves only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high from the cycle after `start` until the last opcode byte is taken. While it is low, the source must hold its byte. A byte offered while the scanner is idle is never consumed. `done` pulses for one cycle once the scan is complete. All result outputs then hold until the next `start`. The mode input is captured when `start` is seen.

Top module: `insn_front_scan`

## Requirements
- R1: Synchronous reset leaves the scanner idle: `in_ready` low, `done` low, and flag word, prefix count, opcode bytes and opcode count all zero.
- R2: A `start` pulse clears every result, captures `mode64` and begins a new scan, even if a scan is already in progress. `in_ready` is high in the following cycle.
- R3: Each legacy prefix sets its own flag bit. The bits are: 0x66 bit0, 0x67 bit1, 0x2E bit2, 0x3E bit3, 0x26 bit4, 0x64 bit5, 0x65 bit6, 0x36 bit7, 0xF0 bit8, 0xF3 bit9, 0xF2 bit10.
- R4: Every prefix byte adds one to `pfx_count`, including a repeat of an earlier prefix, whose flag simply stays set. The count saturates at its all-ones value (15 by default).
- R5: In 64-bit mode a byte 0x40..0x4F is a REX prefix. It sets bit11, copies its low nibble to bits 15:12, and counts as a prefix. The next byte is always taken as an opcode byte, even if it has a prefix value.
- R6: In 32-bit mode bytes 0x40..0x4F are opcode bytes, not prefixes.
- R7: The first byte that is not a prefix becomes opcode byte 0 (`opc_bytes[7:0]`). `opc_count` becomes 1.
- R8: A first opcode byte 0x0F pulls in a second byte (`opc_bytes[15:8]`). If that second byte is 0x38 or 0x3A, a third byte follows (`opc_bytes[23:16]`). `opc_count` gives 1, 2 or 3.
- R9: `opnd_size` is 8 when bit15 (REX.W) is set. Otherwise it is 2 when bit0 is set, and 4 if not.
- R10: `addr_size` is 4 in 32-bit mode, or 2 with bit1 set. It is 8 in 64-bit mode, or 4 with bit1 set.
- R11: `done` is high for exactly one cycle, the cycle after the last opcode byte is accepted. From that cycle on, `in_ready` stays low until the next `start`.
- R12: A byte is consumed only when `in_valid` and `in_ready` are both high. Cycles with `in_valid` low, and bytes offered while idle, change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin (or restart) a scan |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode; sampled with start |
| in_valid | input | 1 | Byte stream valid |
| in_byte | input | 8 | Byte stream data |
| in_ready | output | 1 | Scanner can take a byte |
| done | output | 1 | One-cycle pulse: scan complete |
| pfx_flags | output | 16 | Prefix flag word (R3, R5 encoding) |
| pfx_count | output | 4 | Number of prefix bytes taken |
| opc_bytes | output | 24 | Opcode bytes, byte 0 in the low octet |
| opc_count | output | 2 | Number of opcode bytes (1..3) |
| opnd_size | output | 4 | Effective operand size in bytes |
| addr_size | output | 4 | Effective address size in bytes |

## Verification
Instructions are sent in both modes, each with a different prefix mix. A bare one-byte opcode shows the default sizes. Stacked size prefixes show the toggles, and the full set of segment and repeat prefixes checks every flag bit. The 0x0F, 0x0F 0x38 and 0x0F 0x3A forms check the escape lengths. In 64-bit mode, a REX byte followed by 0x66 shows that REX ends the prefix run. A REX.W byte together with 0x66 shows the forced 8-byte operand size, and the same 0x4X byte in 32-bit mode shows it being taken as an opcode. Further runs cover back-pressure gaps filled with prefix-valued junk, bytes offered while idle, a restart in the middle of a scan, repeated prefixes, and a count pushed past saturation.

// File: rtl/insn_scan_pkg.sv
package insn_scan_pkg;
  localparam int FLAG_W  = 16;
  localparam int LEG_N   = 11;
  localparam int F_OPSZ  = 0;
  localparam int F_ADSZ  = 1;
  localparam int F_CS    = 2;
  localparam int F_DS    = 3;
  localparam int F_ES    = 4;
  localparam int F_FS    = 5;
  localparam int F_GS    = 6;
  localparam int F_SS    = 7;
  localparam int F_LOCK  = 8;
  localparam int F_REPE  = 9;
  localparam int F_REPNE = 10;
  localparam int F_REX   = 11;
  localparam int F_REXLO = 12;
  localparam int F_REXW  = 15;

  localparam logic [7:0] ESC_FIRST = 8'h0F;
  localparam logic [7:0] ESC_MAP_A = 8'h38;
  localparam logic [7:0] ESC_MAP_B = 8'h3A;

  typedef enum logic [2:0] {
    SC_IDLE,
    SC_PFX,
    SC_OP1,
    SC_OP2,
    SC_OP3
  } scan_state_t;
endpackage

// File: rtl/insn_pfx_decode.sv
module insn_pfx_decode
  import insn_scan_pkg::*;
(
  input  logic [7:0]       byte_in,
  input  logic             mode64,
  output logic [LEG_N-1:0] legacy_hit,
  output logic             is_legacy,
  output logic             is_rex
);
  always_comb begin
    legacy_hit = '0;
    case (byte_in)
      8'h66: legacy_hit[F_OPSZ]  = 1'b1;
      8'h67: legacy_hit[F_ADSZ]  = 1'b1;
      8'h2E: legacy_hit[F_CS]    = 1'b1;
      8'h3E: legacy_hit[F_DS]    = 1'b1;
      8'h26: legacy_hit[F_ES]    = 1'b1;
      8'h64: legacy_hit[F_FS]    = 1'b1;
      8'h65: legacy_hit[F_GS]    = 1'b1;
      8'h36: legacy_hit[F_SS]    = 1'b1;
      8'hF0: legacy_hit[F_LOCK]  = 1'b1;
      8'hF3: legacy_hit[F_REPE]  = 1'b1;
      8'hF2: legacy_hit[F_REPNE] = 1'b1;
      default: legacy_hit = '0;
    endcase
  end

  assign is_legacy = |legacy_hit;
  assign is_rex    = mode64 && (byte_in[7:4] == 4'h4);
endmodule

// File: rtl/insn_size_resolve.sv
module insn_size_resolve #(
  parameter int SZ_W = 4
) (
  input  logic            opsz_flag,
  input  logic            adsz_flag,
  input  logic            rex_w,
  input  logic            mode64,
  output logic [SZ_W-1:0] opnd_size,
  output logic [SZ_W-1:0] addr_size
);
  localparam logic [SZ_W-1:0] SZ2 = SZ_W'(2);
  localparam logic [SZ_W-1:0] SZ4 = SZ_W'(4);
  localparam logic [SZ_W-1:0] SZ8 = SZ_W'(8);

  always_comb begin
    if (rex_w)          opnd_size = SZ8;
    else if (opsz_flag) opnd_size = SZ2;
    else                opnd_size = SZ4;

    if (mode64) addr_size = adsz_flag ? SZ4 : SZ8;
    else        addr_size = adsz_flag ? SZ2 : SZ4;
  end
endmodule

// File: rtl/insn_opc_store.sv
module insn_opc_store #(
  parameter int NB    = 3,
  parameter int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]      din,
  output logic [NB*8-1:0] bytes_out
);
  for (genvar g = 0; g < NB; g++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || clr)                     slot_q <= '0;
      else if (wr && idx == IDX_W'(g))    slot_q <= din;
    end
    assign bytes_out[g*8 +: 8] = slot_q;
  end
endmodule

// File: rtl/insn_front_scan.sv
module insn_front_scan
  import insn_scan_pkg::*;
#(
  parameter int PCNT_W  = 4,
  parameter int OPC_MAX = 3,
  parameter int SZ_W    = 4,
  localparam int OCNT_W = $clog2(OPC_MAX + 1),
  localparam int IDX_W  = (OPC_MAX > 1) ? $clog2(OPC_MAX) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 mode64,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  output logic                 done,
  output logic [FLAG_W-1:0]    pfx_flags,
  output logic [PCNT_W-1:0]    pfx_count,
  output logic [OPC_MAX*8-1:0] opc_bytes,
  output logic [OCNT_W-1:0]    opc_count,
  output logic [SZ_W-1:0]      opnd_size,
  output logic [SZ_W-1:0]      addr_size
);
  scan_state_t       st_q;
  logic              mode_q;
  logic              done_q;
  logic [FLAG_W-1:0] flags_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [OCNT_W-1:0] ocnt_q;

  logic [LEG_N-1:0]  leg_hit;
  logic              is_leg, is_rex;
  logic              accept;
  logic              opc_wr;
  logic              esc_more;

  insn_pfx_decode u_pfx (
    .byte_in    (in_byte),
    .mode64     (mode_q),
    .legacy_hit (leg_hit),
    .is_legacy  (is_leg),
    .is_rex     (is_rex)
  );

  insn_size_resolve #(.SZ_W(SZ_W)) u_size (
    .opsz_flag (flags_q[F_OPSZ]),
    .adsz_flag (flags_q[F_ADSZ]),
    .rex_w     (flags_q[F_REXW]),
    .mode64    (mode_q),
    .opnd_size (opnd_size),
    .addr_size (addr_size)
  );

  assign in_ready = (st_q != SC_IDLE);
  assign accept   = in_valid && in_ready && !start;

  // opcode byte is written in any opcode phase, or in prefix phase for a non-prefix byte
  always_comb begin
    opc_wr = 1'b0;
    if (accept) begin
      case (st_q)
        SC_PFX:                 opc_wr = !is_rex && !is_leg;
        SC_OP1, SC_OP2, SC_OP3: opc_wr = 1'b1;
        default:                opc_wr = 1'b0;
      endcase
    end
  end

  assign esc_more = (in_byte == ESC_MAP_A) || (in_byte == ESC_MAP_B);

  insn_opc_store #(.NB(OPC_MAX), .IDX_W(IDX_W)) u_opc (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .wr        (opc_wr),
    .idx       (ocnt_q[IDX_W-1:0]),
    .din       (in_byte),
    .bytes_out (opc_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SC_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      flags_q <= '0;
      pcnt_q  <= '0;
      ocnt_q  <= '0;
    end else if (start) begin
      st_q    <= SC_PFX;
      mode_q  <= mode64;
      done_q  <= 1'b0;
      flags_q <= '0;
      pcnt_q  <= '0;
      ocnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (opc_wr) ocnt_q <= ocnt_q + OCNT_W'(1);
        case (st_q)
          SC_PFX: begin
            if (is_rex) begin
              flags_q[F_REX]           <= 1'b1;
              flags_q[F_REXLO +: 4]    <= in_byte[3:0];
              if (pcnt_q != '1) pcnt_q <= pcnt_q + PCNT_W'(1);
              st_q                     <= SC_OP1;
            end else if (is_leg) begin
              flags_q[LEG_N-1:0]       <= flags_q[LEG_N-1:0] | leg_hit;
              if (pcnt_q != '1) pcnt_q <= pcnt_q + PCNT_W'(1);
            end else if (in_byte == ESC_FIRST) begin
              st_q <= SC_OP2;
            end else begin
              st_q   <= SC_IDLE;
              done_q <= 1'b1;
            end
          end
          SC_OP1: begin
            if (in_byte == ESC_FIRST) st_q <= SC_OP2;
            else begin
              st_q   <= SC_IDLE;
              done_q <= 1'b1;
            end
          end
          SC_OP2: begin
            if (esc_more) st_q <= SC_OP3;
            else begin
              st_q   <= SC_IDLE;
              done_q <= 1'b1;
            end
          end
          SC_OP3: begin
            st_q   <= SC_IDLE;
            done_q <= 1'b1;
          end
          default: st_q <= SC_IDLE;
        endcase
      end
    end
  end

  assign done      = done_q;
  assign pfx_flags = flags_q;
  assign pfx_count = pcnt_q;
  assign opc_count = ocnt_q;

  // ---------------- assertions ----------------
  // R11: done lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: no byte can be taken once the scan has completed
  p_ready_low_at_done_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);

  // R8: a completed scan holds 1..OPC_MAX opcode bytes
  p_opc_count_range_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (opc_count != '0) && (opc_count <= OCNT_W'(OPC_MAX)));

  // R5: after a REX byte no further prefix is counted
  p_rex_closes_pfx_r5: assert property (@(posedge clk) disable iff (rst)
    (pfx_flags[F_REX] && !start) |=> (pfx_count == $past(pfx_count)));

  // R12: nothing changes while the stream is stalled by the scanner
  p_idle_no_consume_r12: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !start) |=> ($stable(pfx_count) && $stable(opc_count) && $stable(pfx_flags)));

  // R9: REX.W forces eight-byte operands
  p_rexw_opnd_r9: assert property (@(posedge clk) disable iff (rst)
    pfx_flags[F_REXW] |-> (opnd_size == SZ_W'(8)));

  // R2: start always opens a fresh scan
  p_start_arms_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (in_ready && pfx_count == '0 && opc_count == '0));
endmodule

// File: tb/tb_insn_front_scan.sv
module tb_insn_front_scan;
  localparam int CLK_PER = 10;

  typedef struct packed {
    logic [15:0] fl;
    logic [3:0]  pc;
    logic [23:0] op;
    logic [1:0]  oc;
    logic [3:0]  os;
    logic [3:0]  as;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode64 = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, done;
  logic [15:0] pfx_flags;
  logic [3:0]  pfx_count;
  logic [23:0] opc_bytes;
  logic [1:0]  opc_count;
  logic [3:0]  opnd_size, addr_size;

  int checks = 0;
  int bad = 0;
  exp_t sbq[$];
  logic [7:0] stim [0:31];
  logic prev_done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  insn_front_scan dut (
    .clk(clk), .rst(rst), .start(start), .mode64(mode64),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready), .done(done),
    .pfx_flags(pfx_flags), .pfx_count(pfx_count), .opc_bytes(opc_bytes),
    .opc_count(opc_count), .opnd_size(opnd_size), .addr_size(addr_size)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic exp_t model(input bit m64, input int n);
    exp_t e;
    int ph;
    logic [7:0] b;
    e = '0;
    ph = 0;
    for (int i = 0; i < n; i++) begin
      b = stim[i];
      if (ph == 0 && m64 && b[7:4] == 4'h4) begin
        e.fl[11] = 1'b1; e.fl[15:12] = b[3:0];
        if (e.pc != 4'hF) e.pc++;
        ph = 1;
      end else if (ph == 0 && (b == 8'h66 || b == 8'h67 || b == 8'h2E || b == 8'h3E ||
               b == 8'h26 || b == 8'h64 || b == 8'h65 || b == 8'h36 ||
               b == 8'hF0 || b == 8'hF3 || b == 8'hF2)) begin
        case (b)
          8'h66: e.fl[0] = 1'b1;   8'h67: e.fl[1] = 1'b1;
          8'h2E: e.fl[2] = 1'b1;   8'h3E: e.fl[3] = 1'b1;
          8'h26: e.fl[4] = 1'b1;   8'h64: e.fl[5] = 1'b1;
          8'h65: e.fl[6] = 1'b1;   8'h36: e.fl[7] = 1'b1;
          8'hF0: e.fl[8] = 1'b1;   8'hF3: e.fl[9] = 1'b1;
          default: e.fl[10] = 1'b1;
        endcase
        if (e.pc != 4'hF) e.pc++;
      end else if (ph == 0 || ph == 1) begin
        e.op[7:0] = b; e.oc = 2'd1;
        ph = (b == 8'h0F) ? 2 : 4;
      end else if (ph == 2) begin
        e.op[15:8] = b; e.oc = 2'd2;
        ph = (b == 8'h38 || b == 8'h3A) ? 3 : 4;
      end else if (ph == 3) begin
        e.op[23:16] = b; e.oc = 2'd3;
        ph = 4;
      end
    end
    e.os = e.fl[15] ? 4'd8 : (e.fl[0] ? 4'd2 : 4'd4);
    e.as = m64 ? (e.fl[1] ? 4'd4 : 4'd8) : (e.fl[1] ? 4'd2 : 4'd4);
    return e;
  endfunction

  task automatic pulse_start(input bit m64);
    @(negedge clk);
    start = 1'b1; mode64 = m64;
    @(negedge clk);
    start = 1'b0;
    chk("R2 ready after start", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && i[0]) begin
        in_valid = 1'b0; in_byte = 8'hF0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_byte = stim[i];
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic run_scan(input bit m64, input int n, input bit gaps);
    sbq.push_back(model(m64, n));
    pulse_start(m64);
    feed(n, gaps);
    repeat (3) @(negedge clk);
    chk("R11 ready low after done", {31'd0, in_ready}, 32'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        exp_t e;
        if (prev_done) chk("R11 done single cycle", 32'd1, 32'd0);
        if (sbq.size() == 0) chk("R11 unexpected done", 32'd1, 32'd0);
        else begin
          e = sbq.pop_front();
          chk("R3/R5 flags", {16'd0, pfx_flags}, {16'd0, e.fl});
          chk("R4 prefix count", {28'd0, pfx_count}, {28'd0, e.pc});
          chk("R7/R8 opcode bytes", {8'd0, opc_bytes}, {8'd0, e.op});
          chk("R8 opcode count", {30'd0, opc_count}, {30'd0, e.oc});
          chk("R9 operand size", {28'd0, opnd_size}, {28'd0, e.os});
          chk("R10 address size", {28'd0, addr_size}, {28'd0, e.as});
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 ready", {31'd0, in_ready}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 flags", {16'd0, pfx_flags}, 32'd0);
    chk("R1 counts", {26'd0, pfx_count, opc_count}, 32'd0);
    chk("R1 opcode", {8'd0, opc_bytes}, 32'd0);

    // R7 bare one-byte opcode, 32-bit
    stim[0] = 8'h90; run_scan(1'b0, 1, 1'b0);
    // R3 R9 R10 size toggles with lock and CS
    stim[0] = 8'h66; stim[1] = 8'h67; stim[2] = 8'hF0; stim[3] = 8'h2E; stim[4] = 8'h01;
    run_scan(1'b0, 5, 1'b0);
    // R3 R8 R12 remaining prefixes, two-byte opcode, with gaps
    stim[0] = 8'h3E; stim[1] = 8'h26; stim[2] = 8'h64; stim[3] = 8'h65; stim[4] = 8'h36;
    stim[5] = 8'hF2; stim[6] = 8'hF3; stim[7] = 8'h0F; stim[8] = 8'h05;
    run_scan(1'b0, 9, 1'b1);
    // R6 0x48 is an opcode in 32-bit mode
    stim[0] = 8'h48; run_scan(1'b0, 1, 1'b0);
    // R5 R8 R9 REX.W with three-byte opcode (0x38 map)
    stim[0] = 8'h48; stim[1] = 8'h0F; stim[2] = 8'h38; stim[3] = 8'h00;
    run_scan(1'b1, 4, 1'b0);
    // R5 REX closes prefix run: 0x66 after REX is the opcode
    stim[0] = 8'h67; stim[1] = 8'h66; stim[2] = 8'h41; stim[3] = 8'h66;
    run_scan(1'b1, 4, 1'b1);
    // R9 REX.W overrides operand-size prefix; R8 0x3A map
    stim[0] = 8'h66; stim[1] = 8'h4F; stim[2] = 8'h0F; stim[3] = 8'h3A; stim[4] = 8'h0F;
    run_scan(1'b1, 5, 1'b0);
    // R4 repeated prefix
    stim[0] = 8'hF3; stim[1] = 8'hF3; stim[2] = 8'hF3; stim[3] = 8'h90;
    run_scan(1'b0, 4, 1'b0);
    // R4 saturation at 15
    for (int i = 0; i < 17; i++) stim[i] = 8'h2E;
    stim[17] = 8'hC3;
    run_scan(1'b0, 18, 1'b0);
    // R8 plain two-byte opcode, 64-bit
    stim[0] = 8'h0F; stim[1] = 8'h1F; run_scan(1'b1, 2, 1'b0);

    // R2 restart in the middle of a scan
    stim[0] = 8'h66; stim[1] = 8'h67;
    pulse_start(1'b0);
    feed(2, 1'b0);
    chk("R2 partial prefixes seen", {28'd0, pfx_count}, 32'd2);
    stim[0] = 8'h90; run_scan(1'b1, 1, 1'b0);

    // R12 bytes offered while idle are not consumed
    in_valid = 1'b1; in_byte = 8'h66;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R12 idle ready low", {31'd0, in_ready}, 32'd0);
    end
    chk("R12 idle flags unchanged", {16'd0, pfx_flags}, 32'd0);
    chk("R12 idle count unchanged", {28'd0, pfx_count}, 32'd0);
    in_valid = 1'b0;
    stim[0] = 8'hC3; run_scan(1'b0, 1, 1'b0);

    repeat (4) @(negedge clk);
    chk("R11 every scan finished", sbq.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule